// File: doc/BRIEF.md
# 32-bit Multi-Function ALU

This block is the arithmetic and logic datapath of a small processor core. It takes two 32-bit operands and a 6-bit function code, and drives one 32-bit result. The operations are add, subtract, multiply, signed divide, signed remainder, four bitwise operations (AND, OR, XOR, XNOR), three shifts (left, logical right, arithmetic right), and three signed compares (equal, less-than, less-or-equal). It has no clock and holds no state. Its result follows the inputs after the combinational delay only.

The top module sends the operands to four function units: arithmetic, bitwise, shift and compare. It then picks the wanted result with the function code. Any code that is not assigned to an operation gives zero. The block therefore has no states and no transitions; the only "state" it has is the decode of the function code.

Top module: `alu32_core`

## Requirements
- R1: Code 6'h00 gives A+B and code 6'h01 gives A-B, both wrapping modulo 2^32.
- R2: Code 6'h02 gives the low 32 bits of A*B.
- R3: Code 6'h03 gives the signed quotient A/B, rounded toward zero. Code 6'h04 gives the signed remainder, which is zero or has the sign of A. The two satisfy quotient*B + remainder = A.
- R4: When B is zero, the divide code gives 0 and the remainder code gives A.
- R5: For A = 32'h80000000 and B = 32'hFFFFFFFF, the divide code gives 32'h80000000 and the remainder code gives 0.
- R6: Code 6'h18 gives A AND B, 6'h1E gives A OR B, 6'h16 gives A XOR B, and 6'h19 gives A XNOR B.
- R7: Code 6'h20 shifts A left and code 6'h21 shifts A right with zero fill. The shift amount is only B[4:0]; bits B[31:5] are ignored.
- R8: Code 6'h23 shifts A right by B[4:0] and fills the vacated bits with copies of A[31].
- R9: Codes 6'h33 (equal), 6'h35 (less-than) and 6'h37 (less-or-equal) treat A and B as signed two's-complement values. Each gives 32'd1 when true and 32'd0 when false.
- R10: Every other code gives 32'd0, whatever the operands are.
- R11: The result changes whenever the inputs change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_i | input | 6 | Function code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; its low 5 bits are the shift amount |
| result_o | output | 32 | Result of the selected function |

## Verification
The assertions are immediate checks placed beside each function unit. They assume the operands and the function code are fully known two-state values: an unknown bit on the divisor or on the code would make the division guards and the decode checks meaningless. They also assume each check is evaluated only after the combinational logic has settled. The stimulus drives only defined values, changes them just after a clock edge, and reads the result half a cycle later. The stimulus covers every one of the 64 codes, including unassigned ones, with random operands mixed with the signed extremes, zero and minus one.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    typedef enum logic [5:0] {
        FN_ADD  = 6'h00,
        FN_SUB  = 6'h01,
        FN_MUL  = 6'h02,
        FN_DIV  = 6'h03,
        FN_REM  = 6'h04,
        FN_XOR  = 6'h16,
        FN_AND  = 6'h18,
        FN_XNOR = 6'h19,
        FN_OR   = 6'h1E,
        FN_SHL  = 6'h20,
        FN_SHR  = 6'h21,
        FN_SRA  = 6'h23,
        FN_CEQ  = 6'h33,
        FN_CLT  = 6'h35,
        FN_CLE  = 6'h37
    } alu_fn_e;

    function automatic logic fn_assigned(input logic [5:0] code);
        case (code)
            FN_ADD, FN_SUB, FN_MUL, FN_DIV, FN_REM,
            FN_XOR, FN_AND, FN_XNOR, FN_OR,
            FN_SHL, FN_SHR, FN_SRA,
            FN_CEQ, FN_CLT, FN_CLE: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

    function automatic logic fn_is_compare(input logic [5:0] code);
        return (code == FN_CEQ) || (code == FN_CLT) || (code == FN_CLE);
    endfunction

endpackage

// File: rtl/alu32_arith.sv
module alu32_arith #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] diff_o,
    output logic [WIDTH-1:0] prod_o,
    output logic [WIDTH-1:0] quot_o,
    output logic [WIDTH-1:0] rem_o
);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] MINUS_ONE = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic              div_zero;
    logic              div_ovf;
    logic [WIDTH-1:0]  safe_divisor;
    logic signed [WIDTH-1:0] s_quot;
    logic signed [WIDTH-1:0] s_rem;

    assign sum_o  = a_i + b_i;
    assign diff_o = a_i - b_i;
    assign prod_o = a_i * b_i;

    assign div_zero     = (b_i == '0);
    assign div_ovf      = (a_i == MOST_NEG) && (b_i == MINUS_ONE);
    assign safe_divisor = (div_zero || div_ovf) ? ONE : b_i;

    assign s_quot = $signed(a_i) / $signed(safe_divisor);
    assign s_rem  = $signed(a_i) % $signed(safe_divisor);

    always_comb begin
        if (div_zero) begin
            quot_o = '0;
            rem_o  = a_i;
        end else if (div_ovf) begin
            quot_o = MOST_NEG;
            rem_o  = '0;
        end else begin
            quot_o = s_quot;
            rem_o  = s_rem;
        end
    end

    always_comb begin
        // R3
        divrem_identity_chk: assert ((quot_o * b_i) + rem_o == a_i)
            else $error("quotient*divisor+remainder does not rebuild dividend");
        // R3
        rem_sign_chk: assert (div_zero || rem_o == '0 || rem_o[WIDTH-1] == a_i[WIDTH-1])
            else $error("remainder sign differs from dividend");
        // R4
        div_zero_chk: assert (!div_zero || (quot_o == '0 && rem_o == a_i))
            else $error("divide by zero result wrong");
        // R1
        add_sub_chk: assert (diff_o + b_i == a_i && sum_o - b_i == a_i)
            else $error("add/sub inconsistent");
    end

endmodule

// File: rtl/alu32_logic.sv
module alu32_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] xor_o,
    output logic [WIDTH-1:0] xnor_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign and_o[i]  = a_i[i] & b_i[i];
        assign or_o[i]   = a_i[i] | b_i[i];
        assign xor_o[i]  = a_i[i] ^ b_i[i];
        assign xnor_o[i] = ~(a_i[i] ^ b_i[i]);
    end

    always_comb begin
        // R6
        xnor_xor_chk: assert (xnor_o == ~xor_o)
            else $error("xnor is not the complement of xor");
        // R6
        and_or_chk: assert ((and_o | xor_o) == or_o && (and_o & xor_o) == '0)
            else $error("and/or/xor inconsistent");
    end

endmodule

// File: rtl/alu32_shift.sv
module alu32_shift #(
    parameter int WIDTH = 32,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [SH_W-1:0]  amt_i,
    output logic [WIDTH-1:0] shl_o,
    output logic [WIDTH-1:0] shr_o,
    output logic [WIDTH-1:0] sra_o
);
    logic [WIDTH-1:0] fill_mask;

    assign shl_o     = a_i << amt_i;
    assign shr_o     = a_i >> amt_i;
    assign fill_mask = ~({WIDTH{1'b1}} >> amt_i);
    assign sra_o     = a_i[WIDTH-1] ? (shr_o | fill_mask) : shr_o;

    always_comb begin
        // R7
        zero_amt_chk: assert (amt_i != '0 || (shl_o == a_i && shr_o == a_i && sra_o == a_i))
            else $error("zero shift changed the operand");
        // R8
        sra_fill_chk: assert (a_i[WIDTH-1] || sra_o == shr_o)
            else $error("arithmetic shift of non-negative differs from logical");
        // R8
        sra_sign_chk: assert (sra_o[WIDTH-1] == a_i[WIDTH-1])
            else $error("arithmetic shift lost the sign");
    end

endmodule

// File: rtl/alu32_cmp.sv
module alu32_cmp #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             eq_o,
    output logic             lt_o,
    output logic             le_o
);
    assign eq_o = (a_i == b_i);
    assign lt_o = $signed(a_i) < $signed(b_i);
    assign le_o = !($signed(b_i) < $signed(a_i));

    always_comb begin
        // R9
        le_cover_chk: assert (le_o == (lt_o || eq_o))
            else $error("less-or-equal disagrees with less-than/equal");
        // R9
        lt_eq_excl_chk: assert (!(lt_o && eq_o))
            else $error("less-than and equal both true");
    end

endmodule

// File: rtl/alu32_core.sv
module alu32_core
    import alu32_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SEL_W = 6
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o
);
    localparam int SH_W = $clog2(WIDTH);

    logic [WIDTH-1:0] sum, diff, prod, quot, rem;
    logic [WIDTH-1:0] land, lor, lxor, lxnor;
    logic [WIDTH-1:0] shl, shr, sra;
    logic             eq, lt, le;

    alu32_arith #(.WIDTH(WIDTH)) u_arith (
        .a_i    (a_i),
        .b_i    (b_i),
        .sum_o  (sum),
        .diff_o (diff),
        .prod_o (prod),
        .quot_o (quot),
        .rem_o  (rem)
    );

    alu32_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i    (a_i),
        .b_i    (b_i),
        .and_o  (land),
        .or_o   (lor),
        .xor_o  (lxor),
        .xnor_o (lxnor)
    );

    alu32_shift #(.WIDTH(WIDTH)) u_shift (
        .a_i   (a_i),
        .amt_i (b_i[SH_W-1:0]),
        .shl_o (shl),
        .shr_o (shr),
        .sra_o (sra)
    );

    alu32_cmp #(.WIDTH(WIDTH)) u_cmp (
        .a_i  (a_i),
        .b_i  (b_i),
        .eq_o (eq),
        .lt_o (lt),
        .le_o (le)
    );

    always_comb begin
        unique case (sel_i)
            FN_ADD:  result_o = sum;
            FN_SUB:  result_o = diff;
            FN_MUL:  result_o = prod;
            FN_DIV:  result_o = quot;
            FN_REM:  result_o = rem;
            FN_AND:  result_o = land;
            FN_OR:   result_o = lor;
            FN_XOR:  result_o = lxor;
            FN_XNOR: result_o = lxnor;
            FN_SHL:  result_o = shl;
            FN_SHR:  result_o = shr;
            FN_SRA:  result_o = sra;
            FN_CEQ:  result_o = {{(WIDTH-1){1'b0}}, eq};
            FN_CLT:  result_o = {{(WIDTH-1){1'b0}}, lt};
            FN_CLE:  result_o = {{(WIDTH-1){1'b0}}, le};
            default: result_o = '0;
        endcase
    end

    always_comb begin
        // R10
        unassigned_zero_chk: assert (fn_assigned(sel_i) || result_o == '0)
            else $error("unassigned code gave nonzero result");
        // R9
        cmp_bool_chk: assert (!fn_is_compare(sel_i) || result_o[WIDTH-1:1] == '0)
            else $error("compare result not 0 or 1");
    end

endmodule

// File: tb/tb_alu32_core.sv
`timescale 1ns/100ps
module tb_alu32_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  sel;
    logic [31:0] a, b;
    logic [31:0] res;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    alu32_core dut (.sel_i(sel), .a_i(a), .b_i(b), .result_o(res));

    // sel, a, b, expected
    localparam int NV = 26;
    localparam logic [101:0] VEC [NV] = '{
        {6'h00, 32'd5,        32'd7,        32'd12},
        {6'h00, 32'hFFFFFFFF, 32'd1,        32'd0},
        {6'h01, 32'd3,        32'd5,        32'hFFFFFFFE},
        {6'h02, 32'h00010000, 32'h00010000, 32'd0},
        {6'h02, 32'hFFFFFFFD, 32'd7,        32'hFFFFFFEB},
        {6'h03, 32'hFFFFFFF9, 32'd2,        32'hFFFFFFFD},
        {6'h04, 32'hFFFFFFF9, 32'd2,        32'hFFFFFFFF},
        {6'h03, 32'd9,        32'd0,        32'd0},
        {6'h04, 32'd9,        32'd0,        32'd9},
        {6'h03, 32'h80000000, 32'hFFFFFFFF, 32'h80000000},
        {6'h04, 32'h80000000, 32'hFFFFFFFF, 32'd0},
        {6'h18, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000},
        {6'h1E, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0},
        {6'h16, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0},
        {6'h19, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF00FF00F},
        {6'h20, 32'd1,        32'd31,       32'h80000000},
        {6'h20, 32'd1,        32'h21,       32'd2},
        {6'h21, 32'h80000000, 32'd4,        32'h08000000},
        {6'h23, 32'h80000000, 32'd4,        32'hF8000000},
        {6'h33, 32'd5,        32'd5,        32'd1},
        {6'h35, 32'hFFFFFFFF, 32'd1,        32'd1},
        {6'h35, 32'd1,        32'hFFFFFFFF, 32'd0},
        {6'h37, 32'd7,        32'd7,        32'd1},
        {6'h37, 32'd8,        32'd7,        32'd0},
        {6'h05, 32'd1,        32'd2,        32'd0},
        {6'h3F, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0}
    };

    function automatic string req_of(input logic [5:0] s);
        case (s)
            6'h00, 6'h01:               return "R1";
            6'h02:                      return "R2";
            6'h03, 6'h04:               return "R3";
            6'h16, 6'h18, 6'h19, 6'h1E: return "R6";
            6'h20, 6'h21:               return "R7";
            6'h23:                      return "R8";
            6'h33, 6'h35, 6'h37:        return "R9";
            default:                    return "R10";
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [5:0] s, input logic [31:0] x, input logic [31:0] y);
        logic signed [31:0] sx, sy;
        int unsigned k;
        sx = x; sy = y; k = y[4:0];
        case (s)
            6'h00: return x + y;
            6'h01: return x - y;
            6'h02: return x * y;
            6'h03: begin
                if (y == 0) return 32'd0;
                if (x == 32'h80000000 && y == 32'hFFFFFFFF) return 32'h80000000;
                return sx / sy;
            end
            6'h04: begin
                if (y == 0) return x;
                if (x == 32'h80000000 && y == 32'hFFFFFFFF) return 32'd0;
                return sx % sy;
            end
            6'h18: return x & y;
            6'h1E: return x | y;
            6'h16: return x ^ y;
            6'h19: return ~(x ^ y);
            6'h20: return x << k;
            6'h21: return x >> k;
            6'h23: return sx >>> k;
            6'h33: return {31'd0, x == y};
            6'h35: return {31'd0, sx < sy};
            6'h37: return {31'd0, sx <= sy};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        n_chk++;
        if (res !== exp) begin
            n_bad++;
            $display("FAIL %s sel=%h a=%h b=%h actual=%h expected=%h", tag, sel, a, b, res, exp);
        end
    endtask

    task automatic apply(input logic [5:0] s, input logic [31:0] x, input logic [31:0] y);
        @(posedge clk);
        #0.5;
        sel = s; a = x; b = y;
        @(negedge clk);
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom_range(0, 7))
            0: return 32'd0;
            1: return 32'hFFFFFFFF;
            2: return 32'h80000000;
            3: return 32'h7FFFFFFF;
            4: return 32'd1;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        sel = 6'h00; a = 32'd0; b = 32'd0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'd0);   // reset state: zero inputs, add gives zero

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][101:96], VEC[i][95:64], VEC[i][63:32]);
            check(req_of(VEC[i][101:96]), VEC[i][31:0]);
        end

        // R4: divide by zero with a negative dividend
        apply(6'h03, 32'hDEADBEEF, 32'd0); check("R4", 32'd0);
        apply(6'h04, 32'hDEADBEEF, 32'd0); check("R4", 32'hDEADBEEF);
        // R5: most negative over minus one
        apply(6'h03, 32'h80000000, 32'hFFFFFFFF); check("R5", 32'h80000000);
        apply(6'h04, 32'h80000000, 32'hFFFFFFFF); check("R5", 32'd0);
        // R8: sign fill across full range
        apply(6'h23, 32'h80000001, 32'd31); check("R8", 32'hFFFFFFFF);
        apply(6'h23, 32'h7FFFFFFF, 32'h3F); check("R8", 32'd0);
        // R7: upper bits of B ignored
        apply(6'h21, 32'hF0000000, 32'hFFFFFFE4); check("R7", 32'h0F000000);
        // R10: unassigned code with extreme operands
        apply(6'h22, 32'h80000000, 32'hFFFFFFFF); check("R10", 32'd0);

        // R11: result follows inputs between clock edges
        @(posedge clk);
        #0.5; sel = 6'h00; a = 32'd40; b = 32'd2;
        #0.5; check("R11", 32'd42);
        a = 32'd100;
        #0.5; check("R11", 32'd102);

        for (int s = 0; s < 64; s++) begin
            for (int j = 0; j < 40; j++) begin
                logic [31:0] x, y;
                x = pick_operand();
                y = pick_operand();
                apply(s[5:0], x, y);
                check(req_of(s[5:0]), model(s[5:0], x, y));
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule